// File: doc/BRIEF.md
# Dual-Channel Timed Overcurrent Latch-Off Supervisor

This block is the digital supervisor for two power switches. Each channel has an enable input and an overcurrent flag that is raised while the analog limiter holds the switch in current regulation. A supply-good flag is shared by both channels. From these inputs each channel drives a switch-on command, a turn-off speed select and a fault pull-low request. The fault request models an active-low, open-drain output: 1 means the pin is pulled low, and 0 means the pin is released.

When a channel is enabled, it turns its switch on and opens a start-up blanking window. During this window faults are not reported and overcurrent timing is held at zero. After the window, an overcurrent flag that stays high starts a fixed latch-off timer while the switch stays on. If regulation is still present when the timer expires, the channel latches its switch off and reports one fault. The fault stays until enable is released. Losing supply-good forces every channel off and clears every latched fault. Both window lengths come from parameters that give clock cycles per millisecond and the length of each window in milliseconds. The enable polarity is also set by a parameter.

Each channel runs a state machine with six states. IDLE_SLOW and IDLE_FAST are the two off states, and they differ only in the turn-off speed they request. BLANK is the start-up window. RUN is on with no regulation. LIMIT is on in regulation while the timer runs. TRIP is latched off with the fault reported. The transitions are these:
- An idle state goes to BLANK when enable becomes active.
- BLANK goes to LIMIT when its window ends with overcurrent present, and to RUN when it ends without overcurrent.
- RUN goes to LIMIT on overcurrent.
- LIMIT goes back to RUN when the overcurrent flag clears.
- LIMIT goes to TRIP when the timer expires.
- Releasing enable takes BLANK, RUN or LIMIT to an idle state, and takes TRIP to IDLE_FAST.
- Loss of supply takes any state to IDLE_SLOW.

Top module: `pg_guard_top`

## Requirements
- R1: While reset is active, and after reset until the first enable, every channel has sw_on=0, fast_off=0 and fault_pull_low=0.
- R2: With supply_ok=1, an active enable turns sw_on on at the next clock edge. While enable is inactive or supply_ok is low, sw_on stays 0.
- R3: For BLANK_MS*CYC_PER_MS cycles after turn-on, fault_pull_low stays 0 even with overcurrent present, and latch-off timing is held at zero. Timing starts only when the window ends, if overcurrent is still present.
- R4: The overcurrent input passes through a two-flop synchronizer, so the channel reacts at the third clock edge after oc_raw changes. Once timing runs, the switch stays on for LATCH_MS*CYC_PER_MS cycles of continuous overcurrent. At the following edge, sw_on drops to 0 and fault_pull_low rises to 1.
- R5: If overcurrent clears before the timer expires, the timer returns to zero and the channel stays on with no fault. A later overcurrent times a full window again from zero.
- R6: A latched fault holds fault_pull_low=1 and sw_on=0 until enable is released, and it clears at the next edge after release. A persisting overcurrent gives exactly one rising edge of fault_pull_low for each latch-off.
- R7: When supply_ok is low, every channel is forced off at the next edge with its fault released and fast_off=0. When supply_ok returns with enable still active, the channel restarts from the blanking window.
- R8: fast_off=0 while the switch is on. A channel disabled with no overcurrent present turns off with fast_off=0. A channel disabled during regulation, or one that has latched off, gives fast_off=1. This select holds until the channel is next turned on.
- R9: The channels are independent. A limit, latch-off or fault on one channel leaves the other channel's sw_on, fast_off and fault_pull_low unchanged.
- R10: With EN_ACTIVE_HIGH=1, en_in=1 enables a channel. With EN_ACTIVE_HIGH=0, en_in=0 enables it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| supply_ok | input | 1 | Shared supply-good flag; low means lockout |
| en_in | input | NUM_CH | Per-channel enable, polarity set by EN_ACTIVE_HIGH |
| oc_raw | input | NUM_CH | Per-channel asynchronous overcurrent (in regulation) flag |
| sw_on | output | NUM_CH | Switch-on command |
| fast_off | output | NUM_CH | Turn-off speed select: 1 fast pull-down, 0 slow ramp |
| fault_pull_low | output | NUM_CH | 1 pulls the active-low fault pin low, 0 releases it |

## Verification
The outputs are decoded from the state register, so a change of enable or supply_ok shows on the outputs one edge after the stimulus. A change of oc_raw shows three edges after the stimulus, because the synchronizer adds two. A latch-off appears BLANK+LATCH+1 edges after an enable that arrives together with an overcurrent. When overcurrent is raised on a running channel, the latch-off appears LATCH+3 edges later. The driver computes each due cycle from these counts and queues the expected output triple (sw_on, fast_off, fault_pull_low) with that cycle. The monitor compares the triple at the falling edge of exactly that cycle. The checks sit one cycle before and one cycle after each window boundary, so a window that is off by one cycle shows up.

// File: rtl/pg_pkg.sv
package pg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE_SLOW,
        ST_IDLE_FAST,
        ST_BLANK,
        ST_RUN,
        ST_LIMIT,
        ST_TRIP
    } ch_state_e;

    function automatic int ms_to_cycles(input int cyc_per_ms, input int ms);
        return cyc_per_ms * ms;
    endfunction

    function automatic int cnt_width(input int a, input int b);
        int m;
        m = (a > b) ? a : b;
        return (m < 2) ? 1 : $clog2(m);
    endfunction

endpackage

// File: rtl/pg_sync.sv
module pg_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q_sync <= '0;
        end else begin
            meta_q <= d_async;
            q_sync <= meta_q;
        end
    end
endmodule

// File: rtl/pg_chan.sv
module pg_chan
    import pg_pkg::*;
#(
    parameter int BLANK_CYC = 12000,
    parameter int LIMIT_CYC = 12000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic en_act,
    input  logic oc_s,
    output logic sw_on,
    output logic fast_off,
    output logic fault_pull_low
);
    localparam int CNT_W = cnt_width(BLANK_CYC, LIMIT_CYC);
    localparam logic [CNT_W-1:0] BLANK_LAST = CNT_W'(BLANK_CYC - 1);
    localparam logic [CNT_W-1:0] LIMIT_LAST = CNT_W'(LIMIT_CYC - 1);

    ch_state_e        state_q, state_nx;
    logic [CNT_W-1:0] cnt_q, cnt_nx;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE_SLOW;
            cnt_q   <= '0;
        end else begin
            state_q <= state_nx;
            cnt_q   <= cnt_nx;
        end
    end

    // Transitions
    always_comb begin
        state_nx = state_q;
        cnt_nx   = cnt_q;
        if (!supply_ok) begin
            state_nx = ST_IDLE_SLOW;
            cnt_nx   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE_SLOW, ST_IDLE_FAST: begin
                    if (en_act) begin
                        state_nx = ST_BLANK;
                        cnt_nx   = '0;
                    end
                end
                ST_BLANK: begin
                    if (!en_act) begin
                        state_nx = oc_s ? ST_IDLE_FAST : ST_IDLE_SLOW;
                        cnt_nx   = '0;
                    end else if (cnt_q == BLANK_LAST) begin
                        state_nx = oc_s ? ST_LIMIT : ST_RUN;
                        cnt_nx   = '0;
                    end else begin
                        cnt_nx = cnt_q + 1'b1;
                    end
                end
                ST_RUN: begin
                    if (!en_act) begin
                        state_nx = oc_s ? ST_IDLE_FAST : ST_IDLE_SLOW;
                        cnt_nx   = '0;
                    end else if (oc_s) begin
                        state_nx = ST_LIMIT;
                        cnt_nx   = '0;
                    end
                end
                ST_LIMIT: begin
                    if (!en_act) begin
                        state_nx = ST_IDLE_FAST;
                        cnt_nx   = '0;
                    end else if (!oc_s) begin
                        state_nx = ST_RUN;
                        cnt_nx   = '0;
                    end else if (cnt_q == LIMIT_LAST) begin
                        state_nx = ST_TRIP;
                        cnt_nx   = '0;
                    end else begin
                        cnt_nx = cnt_q + 1'b1;
                    end
                end
                ST_TRIP: begin
                    if (!en_act) begin
                        state_nx = ST_IDLE_FAST;
                    end
                end
                default: begin
                    state_nx = ST_IDLE_SLOW;
                    cnt_nx   = '0;
                end
            endcase
        end
    end

    // Outputs decoded from state
    always_comb begin
        sw_on          = 1'b0;
        fast_off       = 1'b0;
        fault_pull_low = 1'b0;
        unique case (state_q)
            ST_IDLE_SLOW: ;
            ST_IDLE_FAST: fast_off = 1'b1;
            ST_BLANK, ST_RUN, ST_LIMIT: sw_on = 1'b1;
            ST_TRIP: begin
                fast_off       = 1'b1;
                fault_pull_low = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pg_guard_top.sv
module pg_guard_top
    import pg_pkg::*;
#(
    parameter int NUM_CH         = 2,
    parameter int CYC_PER_MS     = 1000,
    parameter int BLANK_MS       = 12,
    parameter int LATCH_MS       = 12,
    parameter bit EN_ACTIVE_HIGH = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              supply_ok,
    input  logic [NUM_CH-1:0] en_in,
    input  logic [NUM_CH-1:0] oc_raw,
    output logic [NUM_CH-1:0] sw_on,
    output logic [NUM_CH-1:0] fast_off,
    output logic [NUM_CH-1:0] fault_pull_low
);
    localparam int BLANK_CYC = ms_to_cycles(CYC_PER_MS, BLANK_MS);
    localparam int LIMIT_CYC = ms_to_cycles(CYC_PER_MS, LATCH_MS);

    logic [NUM_CH-1:0] en_act;
    logic [NUM_CH-1:0] oc_s;

    generate
        if (EN_ACTIVE_HIGH) begin : g_en_hi
            assign en_act = en_in;
        end else begin : g_en_lo
            assign en_act = ~en_in;
        end
    endgenerate

    pg_sync #(.W(NUM_CH)) u_oc_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (oc_raw),
        .q_sync  (oc_s)
    );

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
            pg_chan #(
                .BLANK_CYC (BLANK_CYC),
                .LIMIT_CYC (LIMIT_CYC)
            ) u_chan (
                .clk            (clk),
                .rst_n          (rst_n),
                .supply_ok      (supply_ok),
                .en_act         (en_act[i]),
                .oc_s           (oc_s[i]),
                .sw_on          (sw_on[i]),
                .fast_off       (fast_off[i]),
                .fault_pull_low (fault_pull_low[i])
            );
        end
    endgenerate
endmodule

// File: rtl/pg_guard_chk.sv
module pg_guard_chk #(
    parameter int NUM_CH         = 2,
    parameter bit EN_ACTIVE_HIGH = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              supply_ok,
    input logic [NUM_CH-1:0] en_in,
    input logic [NUM_CH-1:0] sw_on,
    input logic [NUM_CH-1:0] fast_off,
    input logic [NUM_CH-1:0] fault_pull_low
);
    logic [NUM_CH-1:0] en_act;
    assign en_act = EN_ACTIVE_HIGH ? en_in : ~en_in;

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
            a_r7_supply_off: assert property (@(posedge clk) disable iff (!rst_n)
                !supply_ok |=> (!sw_on[i] && !fault_pull_low[i] && !fast_off[i]));

            a_r2_no_spurious_on: assert property (@(posedge clk) disable iff (!rst_n)
                (!en_act[i] || !supply_ok) |=> !sw_on[i]);

            a_r6_fault_hold: assert property (@(posedge clk) disable iff (!rst_n)
                (fault_pull_low[i] && en_act[i] && supply_ok) |=> fault_pull_low[i]);

            a_r6_fault_clear: assert property (@(posedge clk) disable iff (!rst_n)
                (fault_pull_low[i] && !en_act[i]) |=> !fault_pull_low[i]);

            a_r6_fault_switch_off: assert property (@(posedge clk) disable iff (!rst_n)
                fault_pull_low[i] |-> !sw_on[i]);

            a_r4_trip_from_on: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(fault_pull_low[i]) |-> $past(sw_on[i]));

            a_r8_fast_only_off: assert property (@(posedge clk) disable iff (!rst_n)
                sw_on[i] |-> !fast_off[i]);
        end
    endgenerate
endmodule

bind pg_guard_top pg_guard_chk #(
    .NUM_CH         (NUM_CH),
    .EN_ACTIVE_HIGH (EN_ACTIVE_HIGH)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .supply_ok      (supply_ok),
    .en_in          (en_in),
    .sw_on          (sw_on),
    .fast_off       (fast_off),
    .fault_pull_low (fault_pull_low)
);

// File: tb/pg_guard_top_tb.sv
`timescale 1ns/1ps
module pg_guard_top_tb;
    localparam int NCH = 2;
    localparam int CPM = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic           rst_n;
    logic           supply_ok;
    logic [NCH-1:0] en, oc, en_inv;
    logic [NCH-1:0] sw_on, fast_off, flt;
    logic [NCH-1:0] sw_inv, fast_inv, flt_inv;

    pg_guard_top #(.NUM_CH(NCH), .CYC_PER_MS(CPM)) u_dut (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .en_in(en), .oc_raw(oc),
        .sw_on(sw_on), .fast_off(fast_off), .fault_pull_low(flt)
    );

    pg_guard_top #(.NUM_CH(NCH), .CYC_PER_MS(CPM), .EN_ACTIVE_HIGH(1'b0)) u_dut_inv (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .en_in(en_inv), .oc_raw('0),
        .sw_on(sw_inv), .fast_off(fast_inv), .fault_pull_low(flt_inv)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int errors = 0;
    int rise0  = 0;
    logic prev_f0 = 1'b0;

    int         q_due[$];
    int         q_ch[$];
    logic [2:0] q_val[$];
    string      q_tag[$];

    task automatic check_now(string tag, logic [2:0] act, logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual(sw,fast,flt)=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic check_int(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Driver side: queue an expected triple due d edges from now
    task automatic expect_after(int d, int ch, logic [2:0] val, string tag);
        int due;
        int idx;
        due = cyc + d;
        idx = 0;
        while (idx < q_due.size() && q_due[idx] <= due) idx++;
        q_due.insert(idx, due);
        q_ch.insert(idx, ch);
        q_val.insert(idx, val);
        q_tag.insert(idx, tag);
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compare queued items when due
    always @(negedge clk) begin
        while (q_due.size() > 0 && q_due[0] <= cyc) begin
            check_now(q_tag[0],
                      {sw_on[q_ch[0]], fast_off[q_ch[0]], flt[q_ch[0]]},
                      q_val[0]);
            void'(q_due.pop_front());
            void'(q_ch.pop_front());
            void'(q_val.pop_front());
            void'(q_tag.pop_front());
        end
        if (flt[0] && !prev_f0) rise0++;
        prev_f0 = flt[0];
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; supply_ok = 1'b1; en = '0; oc = '0; en_inv = '1;
        tick(3);
        // R1: reset state
        check_now("R1 reset ch0", {sw_on[0], fast_off[0], flt[0]}, 3'b000);
        check_now("R1 reset ch1", {sw_on[1], fast_off[1], flt[1]}, 3'b000);
        rst_n = 1'b1;
        tick(2);
        check_now("R1 idle after reset", {sw_on[0], fast_off[0], flt[0]}, 3'b000);

        // R10: active-low enable variant
        en_inv[0] = 1'b0;
        tick(2);
        check_now("R10 low enable turns on", {sw_inv[0], sw_inv[1], flt_inv[0]}, 3'b100);
        en_inv[0] = 1'b1;
        tick(2);
        check_now("R10 high input disables", {sw_inv[0], sw_inv[1], flt_inv[0]}, 3'b000);

        // R2 R3 R4 R9: enable both, overcurrent on ch0 from the start
        en = 2'b11; oc = 2'b01;
        expect_after(1,   0, 3'b100, "R2 ch0 on");
        expect_after(1,   1, 3'b100, "R2 ch1 on");
        expect_after(48,  0, 3'b100, "R3 blank end no fault");
        expect_after(96,  0, 3'b100, "R4 one cycle before trip");
        expect_after(97,  0, 3'b011, "R4 trip");
        expect_after(97,  1, 3'b100, "R9 ch1 unaffected");
        expect_after(150, 0, 3'b011, "R6 fault held under overcurrent");
        expect_after(150, 1, 3'b100, "R9 ch1 still on");
        tick(160);
        check_int("R6 single fault report", rise0, 1);
        en[0] = 1'b0; oc[0] = 1'b0;
        expect_after(1, 0, 3'b010, "R6 release clears fault R8 fast after trip");
        tick(5);

        // R5: recovery before expiry, then full window again
        en[0] = 1'b1;
        tick(60);
        oc[0] = 1'b1;
        expect_after(19, 0, 3'b100, "R5 limiting");
        tick(20);
        oc[0] = 1'b0;
        expect_after(30, 0, 3'b100, "R5 recovered no fault");
        tick(40);
        oc[0] = 1'b1;
        expect_after(50, 0, 3'b100, "R5 restart from zero");
        expect_after(51, 0, 3'b011, "R5 trip after full window");
        tick(55);
        check_int("R6 one report per latch-off", rise0, 2);
        en[0] = 1'b0; oc[0] = 1'b0;
        tick(3);

        // R8: slow disable
        en[0] = 1'b1;
        tick(60);
        en[0] = 1'b0;
        expect_after(1, 0, 3'b000, "R8 slow off without overcurrent");
        tick(3);

        // R8: fast disable during regulation
        en[0] = 1'b1;
        tick(60);
        oc[0] = 1'b1;
        tick(10);
        en[0] = 1'b0;
        expect_after(1, 0, 3'b010, "R8 fast off during regulation");
        oc[0] = 1'b0;
        tick(3);

        // R7: supply loss clears latch, recovery restarts blanking
        en[0] = 1'b1; oc[0] = 1'b1;
        expect_after(99, 0, 3'b011, "R7 pre tripped");
        tick(100);
        supply_ok = 1'b0;
        expect_after(1, 0, 3'b000, "R7 supply loss releases fault");
        expect_after(1, 1, 3'b000, "R7 ch1 forced off");
        expect_after(4, 0, 3'b000, "R7 held off in lockout");
        tick(5);
        oc[0] = 1'b0;
        supply_ok = 1'b1;
        expect_after(1, 0, 3'b100, "R7 restart after supply return");
        expect_after(1, 1, 3'b100, "R7 ch1 restart");
        tick(5);
        en = '0;
        tick(5);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule